// File: doc/BRIEF.md
# Effective Address Mode Decoder

This block turns a 6-bit addressing-mode field into a decoded operand-location descriptor. It pulls any extension words that follow the opcode from an instruction-stream port, one 16-bit word per handshake. A decode begins with a one-cycle `start` that presents the mode field, the immediate operand size and a flat snapshot of sixteen 32-bit registers. The block then asks for exactly as many extension words as the mode needs. It finishes with a single-cycle `done` that carries the descriptor, the error status and the number of instruction bytes consumed.

The descriptor holds the kind of the mode as a flag vector and the base register number. It also holds the index register number and the combined base displacement, with the scaled index already folded in where the mode asks for it. The remaining fields are the outer displacement, the absolute address and the immediate value. A downstream address unit adds the base register or PC, performs any memory indirection and applies any register update. None of that happens here.

Top module: `ea_mode_decoder`

## Requirements
- R1: While `rstN` is low and in the first cycle after it rises, `done`, `extReady`, `descValid` and `extBytes` are all zero.
- R2: Mode field bits 5:3 select the mode and bits 2:0 the register or sub-mode. Modes 0 to 4 consume no words. Mode 0 sets flag bit 0 (direct) with base register 0–7. Mode 1 sets flag bit 0 with base register 8–15. Mode 2 sets no mode flag. Mode 3 sets bit 1 (post-increment) and mode 4 sets bit 2 (pre-decrement), both with base register 8+reg.
- R3: Mode 5 consumes one word and sets flag bit 3 (offset) with base register 8+reg. Mode 7 sub-mode 2 consumes one word and sets bits 3 and 6 (PC-relative). In both cases the word is sign-extended into `baseDisp`.
- R4: Mode 7 sub-mode 0 consumes one word and places its sign extension in `absAddr`. Sub-mode 1 consumes two words, first word high, to form `absAddr`. Both set flag bit 5 (absolute).
- R5: Mode 7 sub-mode 4 sets flag bit 7 (immediate). The immediate size code selects the words consumed. Code 0 (byte) takes one word and sign-extends its low 8 bits. Code 1 (word) takes one word and sign-extends it. Code 2 takes 2 words, code 3 takes 4 words and code 4 takes 6 words. The words are right-justified in `immed`, first word most significant.
- R6: Mode 6 sets flag bit 4 (indexed) and mode 7 sub-mode 3 sets bits 4 and 6; both take one extension word first. Word bits 15:12 pick the index register. When bit 11 is 0, the low 16 bits of that register are sign-extended. Bits 10:9 give a left shift of 0–3. When bit 8 is 0 (brief form), `baseDisp` is the scaled index plus the sign-extended bits 7:0, and `outerDisp` is 0.
- R7: When bit 8 is 1 (full form), bit 7 sets flag bit 8 (base suppressed). Bits 5:4 size the base displacement and bits 1:0 the outer one: 2 is one sign-extended word, 3 is two words high first, any other value is none. Bits 1:0 nonzero set flag bit 9 (memory indirect). Bits {6,2} select the index use: 00 adds it to `baseDisp`, 01 adds it to `outerDisp`, 10 omits it.
- R8: Mode 7 sub-modes 5–7, an immediate size code above 4, and a full-form word with bits 6 and 2 both set each give `done` with `illegal` high and `descValid` low. The full-form case counts its extension word; the other cases consume nothing.
- R9: A word presented with `extFault` high during a handshake ends the decode at once. `done` follows with `fault` high, `descValid` low, and the faulted word not counted.
- R10: `extReady` is high exactly while words remain to be taken, and a word is accepted only when `extValid` and `extReady` are both high. `done` is a one-cycle pulse one cycle after the last accepted word, or after `start` when none is needed. `extBytes` is then twice the number of words accepted.
- R11: A `start` that arrives while a decode is in progress is ignored and does not alter the result.
- R12: Descriptor fields the decoded mode does not use read zero at `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a decode (taken only when idle) |
| modeReg | input | 6 | Mode field: bits 5:3 mode, bits 2:0 register / sub-mode |
| immSize | input | 3 | Immediate operand size code (0 byte, 1 word, 2 long, 3 eight bytes, 4 twelve bytes) |
| regSnap | input | 512 | Sixteen 32-bit registers, register k at bits 32k+31:32k |
| extValid | input | 1 | Extension word available |
| extData | input | 16 | Extension word |
| extFault | input | 1 | The presented word could not be fetched |
| extReady | output | 1 | Decoder will take the presented word |
| done | output | 1 | One-cycle completion pulse |
| descValid | output | 1 | Descriptor is valid (done without error) |
| illegal | output | 1 | Illegal mode or extension encoding (with done) |
| fault | output | 1 | Fetch fault aborted the decode (with done) |
| eaFlags | output | 10 | Mode flags, bit positions as in R2–R7 |
| baseReg | output | 4 | Base register number |
| idxReg | output | 4 | Index register number |
| baseDisp | output | 32 | Base displacement including pre-index |
| outerDisp | output | 32 | Outer displacement including post-index |
| absAddr | output | 32 | Absolute address |
| immed | output | 96 | Immediate operand, right-justified |
| extBytes | output | 4 | Extension bytes consumed |

## Verification
The bound checker watches the handshake and completion protocol on every cycle. It checks that `done` is a lone pulse and that ready is low once done. It checks that the byte count is even and never moves while no word is taken. It also checks that a faulted handshake leads straight to a faulted completion, that error and valid flags appear only with `done`, and that the two errors never coincide. Only the bench scenarios can show that the descriptor values are right. That covers the sign extension, scaling and placement of the index, the high-first assembly of long words, the immediate sizes, zeroing of unused fields, and the exact completion cycle under stalls and a stray `start`.

// File: rtl/ea_dec_pkg.sv
package ea_dec_pkg;
  localparam int WORD_W    = 16;
  localparam int ADDR_W    = 32;
  localparam int NUM_REGS  = 16;
  localparam int REG_IDX_W = $clog2(NUM_REGS);
  localparam int IMM_WORDS = 6;
  localparam int IMM_W     = IMM_WORDS * WORD_W;
  localparam int LEFT_W    = $clog2(IMM_WORDS + 1);
  localparam int CNT_W     = $clog2(2 * IMM_WORDS + 1);
  localparam int SNAP_W    = NUM_REGS * ADDR_W;

  // first member is the most significant bit
  typedef struct packed {
    logic memIndir;   // bit 9
    logic baseSupp;   // bit 8
    logic immediate;  // bit 7
    logic pcRel;      // bit 6
    logic absolute;   // bit 5
    logic indexed;    // bit 4
    logic offset;     // bit 3
    logic preDec;     // bit 2
    logic postInc;    // bit 1
    logic direct;     // bit 0
  } eaFlags_t;

  localparam int FLAG_W = $bits(eaFlags_t);

  typedef enum logic [2:0] {
    S_IDLE, S_SIMPLE, S_EXT, S_BASE, S_OUTER, S_DONE
  } ctlState_t;

  typedef struct packed {
    logic clr;       // new decode accepted
    logic take;      // a word is accepted this cycle
    logic extCap;    // the accepted word is an index extension word
    logic bdEnd;     // last word of the base displacement
    logic odEnd;     // last word of the outer displacement
    logic simpEnd;   // last word of a non-indexed operand
    logic longDisp;  // displacement ending now spans two words
  } ctlStrobe_t;
endpackage

// File: rtl/ea_dec_ctrl.sv
module ea_dec_ctrl
  import ea_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [5:0]        modeReg,
  input  logic [2:0]        immSize,
  input  logic              extValid,
  input  logic [WORD_W-1:0] extData,
  input  logic              extFault,
  output logic              extReady,
  output logic              done,
  output logic              illegal,
  output logic              fault,
  output ctlStrobe_t        stb
);
  ctlState_t         state, nxtState;
  logic [LEFT_W-1:0] wordsLeft, nxtLeft;
  logic [1:0]        odWords, nxtOdWords;
  logic              dispLong, nxtDispLong;
  logic              illegalQ, nxtIllegal;
  logic              faultQ, nxtFault;
  logic              accept, faultHit;
  logic [1:0]        fullBd, fullOd;
  logic              unusedExt;

  function automatic logic [LEFT_W-1:0] immWords(input logic [2:0] code);
    case (code)
      3'd0, 3'd1: return LEFT_W'(1);
      3'd2:       return LEFT_W'(2);
      3'd3:       return LEFT_W'(4);
      3'd4:       return LEFT_W'(6);
      default:    return '0;
    endcase
  endfunction

  function automatic logic [1:0] dispWords(input logic [1:0] code);
    case (code)
      2'd2:    return 2'd1;
      2'd3:    return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  assign extReady = (state == S_SIMPLE) || (state == S_EXT) ||
                    (state == S_BASE) || (state == S_OUTER);
  assign accept   = extReady && extValid && !extFault;
  assign faultHit = extReady && extValid && extFault;
  assign done     = (state == S_DONE);
  assign illegal  = done && illegalQ;
  assign fault    = done && faultQ;
  assign fullBd   = dispWords(extData[5:4]);
  assign fullOd   = dispWords(extData[1:0]);
  assign unusedExt = ^{extData[15:9], extData[7], extData[3]};

  always_comb begin
    stb         = '0;
    nxtState    = state;
    nxtLeft     = wordsLeft;
    nxtOdWords  = odWords;
    nxtDispLong = dispLong;
    nxtIllegal  = illegalQ;
    nxtFault    = faultQ;
    if (faultHit) begin
      nxtFault = 1'b1;
      nxtState = S_DONE;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          stb.clr    = 1'b1;
          nxtIllegal = 1'b0;
          nxtFault   = 1'b0;
          nxtState   = S_DONE;
          case (modeReg[5:3])
            3'd5: begin nxtState = S_SIMPLE; nxtLeft = LEFT_W'(1); end
            3'd6: nxtState = S_EXT;
            3'd7: case (modeReg[2:0])
              3'd0, 3'd2: begin nxtState = S_SIMPLE; nxtLeft = LEFT_W'(1); end
              3'd1: begin nxtState = S_SIMPLE; nxtLeft = LEFT_W'(2); end
              3'd3: nxtState = S_EXT;
              3'd4: begin
                if (immWords(immSize) == '0) nxtIllegal = 1'b1;
                else begin
                  nxtState = S_SIMPLE;
                  nxtLeft  = immWords(immSize);
                end
              end
              default: nxtIllegal = 1'b1;
            endcase
            default: ;
          endcase
        end
        S_SIMPLE: if (accept) begin
          stb.take = 1'b1;
          if (wordsLeft == LEFT_W'(1)) begin
            stb.simpEnd = 1'b1;
            nxtState    = S_DONE;
          end else nxtLeft = wordsLeft - LEFT_W'(1);
        end
        S_EXT: if (accept) begin
          stb.take   = 1'b1;
          stb.extCap = 1'b1;
          if (!extData[8]) nxtState = S_DONE;
          else if (extData[6] && extData[2]) begin
            nxtIllegal = 1'b1;
            nxtState   = S_DONE;
          end else begin
            nxtOdWords = fullOd;
            if (fullBd != 2'd0) begin
              nxtState    = S_BASE;
              nxtLeft     = LEFT_W'(fullBd);
              nxtDispLong = (fullBd == 2'd2);
            end else if (fullOd != 2'd0) begin
              nxtState    = S_OUTER;
              nxtLeft     = LEFT_W'(fullOd);
              nxtDispLong = (fullOd == 2'd2);
            end else nxtState = S_DONE;
          end
        end
        S_BASE: if (accept) begin
          stb.take = 1'b1;
          if (wordsLeft == LEFT_W'(1)) begin
            stb.bdEnd    = 1'b1;
            stb.longDisp = dispLong;
            if (odWords != 2'd0) begin
              nxtState    = S_OUTER;
              nxtLeft     = LEFT_W'(odWords);
              nxtDispLong = (odWords == 2'd2);
            end else nxtState = S_DONE;
          end else nxtLeft = wordsLeft - LEFT_W'(1);
        end
        S_OUTER: if (accept) begin
          stb.take = 1'b1;
          if (wordsLeft == LEFT_W'(1)) begin
            stb.odEnd    = 1'b1;
            stb.longDisp = dispLong;
            nxtState     = S_DONE;
          end else nxtLeft = wordsLeft - LEFT_W'(1);
        end
        S_DONE: nxtState = S_IDLE;
        default: nxtState = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      wordsLeft <= '0;
      odWords   <= '0;
      dispLong  <= 1'b0;
      illegalQ  <= 1'b0;
      faultQ    <= 1'b0;
    end else begin
      state     <= nxtState;
      wordsLeft <= nxtLeft;
      odWords   <= nxtOdWords;
      dispLong  <= nxtDispLong;
      illegalQ  <= nxtIllegal;
      faultQ    <= nxtFault;
    end
  end
endmodule

// File: rtl/ea_dec_dpath.sv
module ea_dec_dpath
  import ea_dec_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobe_t           stb,
  input  logic [5:0]           modeReg,
  input  logic [2:0]           immSize,
  input  logic [WORD_W-1:0]    extData,
  input  logic [SNAP_W-1:0]    regSnap,
  output eaFlags_t             flags,
  output logic [REG_IDX_W-1:0] baseReg,
  output logic [REG_IDX_W-1:0] idxReg,
  output logic [ADDR_W-1:0]    baseDisp,
  output logic [ADDR_W-1:0]    outerDisp,
  output logic [ADDR_W-1:0]    absAddr,
  output logic [IMM_W-1:0]     immed,
  output logic [CNT_W-1:0]     extBytes
);
  logic [ADDR_W-1:0] regArr [NUM_REGS];
  logic [5:0]        modeQ;
  logic [2:0]        sizeQ;
  logic [IMM_W-1:0]  acc, shifted;
  logic [ADDR_W-1:0] idxRaw, idxSized, idxScaled;
  logic [ADDR_W-1:0] wordSext, longVal, dispVal, briefDisp;

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_regs
    assign regArr[k] = regSnap[k*ADDR_W +: ADDR_W];
  end

  function automatic eaFlags_t modeFlags(input logic [5:0] m);
    eaFlags_t f;
    f = '0;
    case (m[5:3])
      3'd0, 3'd1: f.direct  = 1'b1;
      3'd3:       f.postInc = 1'b1;
      3'd4:       f.preDec  = 1'b1;
      3'd5:       f.offset  = 1'b1;
      3'd6:       f.indexed = 1'b1;
      3'd7: case (m[2:0])
        3'd0, 3'd1: f.absolute = 1'b1;
        3'd2: begin f.pcRel = 1'b1; f.offset  = 1'b1; end
        3'd3: begin f.pcRel = 1'b1; f.indexed = 1'b1; end
        3'd4: f.immediate = 1'b1;
        default: ;
      endcase
      default: ;
    endcase
    return f;
  endfunction

  assign idxRaw    = regArr[extData[15:12]];
  assign idxSized  = extData[11] ? idxRaw
                                 : {{(ADDR_W-WORD_W){idxRaw[WORD_W-1]}}, idxRaw[WORD_W-1:0]};
  assign idxScaled = idxSized << extData[10:9];
  assign briefDisp = {{(ADDR_W-8){extData[7]}}, extData[7:0]};
  assign wordSext  = {{(ADDR_W-WORD_W){extData[WORD_W-1]}}, extData};
  assign longVal   = {acc[WORD_W-1:0], extData};
  assign dispVal   = stb.longDisp ? longVal : wordSext;
  assign shifted   = {acc[IMM_W-WORD_W-1:0], extData};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags     <= '0;
      baseReg   <= '0;
      idxReg    <= '0;
      baseDisp  <= '0;
      outerDisp <= '0;
      absAddr   <= '0;
      immed     <= '0;
      extBytes  <= '0;
      acc       <= '0;
      modeQ     <= '0;
      sizeQ     <= '0;
    end else begin
      if (stb.clr) begin
        flags     <= modeFlags(modeReg);
        baseReg   <= {(modeReg[5:3] != 3'd0) && (modeReg[5:3] != 3'd7), modeReg[2:0]};
        idxReg    <= '0;
        baseDisp  <= '0;
        outerDisp <= '0;
        absAddr   <= '0;
        immed     <= '0;
        extBytes  <= '0;
        acc       <= '0;
        modeQ     <= modeReg;
        sizeQ     <= immSize;
      end
      if (stb.take) begin
        acc      <= shifted;
        extBytes <= extBytes + CNT_W'(2);
      end
      if (stb.extCap) begin
        idxReg <= extData[15:12];
        if (!extData[8]) begin
          baseDisp  <= idxScaled + briefDisp;
          outerDisp <= '0;
        end else begin
          flags.baseSupp <= extData[7];
          flags.memIndir <= (extData[1:0] != 2'd0);
          baseDisp  <= (!extData[6] && !extData[2]) ? idxScaled : '0;
          outerDisp <= (!extData[6] &&  extData[2]) ? idxScaled : '0;
        end
      end
      if (stb.bdEnd) baseDisp  <= baseDisp + dispVal;
      if (stb.odEnd) outerDisp <= outerDisp + dispVal;
      if (stb.simpEnd) begin
        if (modeQ[5:3] == 3'd5 || modeQ == 6'o72) baseDisp <= wordSext;
        else if (modeQ == 6'o70) absAddr <= wordSext;
        else if (modeQ == 6'o71) absAddr <= longVal;
        else begin
          case (sizeQ)
            3'd0:    immed <= {{(IMM_W-ADDR_W){1'b0}}, briefDisp};
            3'd1:    immed <= {{(IMM_W-ADDR_W){1'b0}}, wordSext};
            default: immed <= shifted;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/ea_mode_decoder.sv
module ea_mode_decoder
  import ea_dec_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [5:0]           modeReg,
  input  logic [2:0]           immSize,
  input  logic [SNAP_W-1:0]    regSnap,
  input  logic                 extValid,
  input  logic [WORD_W-1:0]    extData,
  input  logic                 extFault,
  output logic                 extReady,
  output logic                 done,
  output logic                 descValid,
  output logic                 illegal,
  output logic                 fault,
  output logic [FLAG_W-1:0]    eaFlags,
  output logic [REG_IDX_W-1:0] baseReg,
  output logic [REG_IDX_W-1:0] idxReg,
  output logic [ADDR_W-1:0]    baseDisp,
  output logic [ADDR_W-1:0]    outerDisp,
  output logic [ADDR_W-1:0]    absAddr,
  output logic [IMM_W-1:0]     immed,
  output logic [CNT_W-1:0]     extBytes
);
  ctlStrobe_t stb;
  eaFlags_t   flagsQ;

  ea_dec_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .modeReg(modeReg), .immSize(immSize),
    .extValid(extValid), .extData(extData), .extFault(extFault),
    .extReady(extReady), .done(done), .illegal(illegal), .fault(fault), .stb(stb)
  );

  ea_dec_dpath i_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .modeReg(modeReg), .immSize(immSize),
    .extData(extData), .regSnap(regSnap), .flags(flagsQ), .baseReg(baseReg),
    .idxReg(idxReg), .baseDisp(baseDisp), .outerDisp(outerDisp), .absAddr(absAddr),
    .immed(immed), .extBytes(extBytes)
  );

  assign eaFlags   = flagsQ;
  assign descValid = done && !illegal && !fault;
endmodule

// File: rtl/ea_mode_decoder_chk.sv
module ea_mode_decoder_chk (
  input logic       clk,
  input logic       rstN,
  input logic       extValid,
  input logic       extFault,
  input logic       extReady,
  input logic       done,
  input logic       descValid,
  input logic       illegal,
  input logic       fault,
  input logic [3:0] extBytes
);
  AST_RESET_QUIET: assert property (@(posedge clk) $rose(rstN) |-> (!done && !extReady && extBytes == 4'd0)); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN) done |=> !done); // R10
  AST_NO_READY_AT_DONE: assert property (@(posedge clk) disable iff (!rstN) done |-> !extReady); // R10
  AST_EVEN_BYTES: assert property (@(posedge clk) disable iff (!rstN) done |-> !extBytes[0]); // R10
  AST_BYTES_HOLD: assert property (@(posedge clk) disable iff (!rstN) (extReady && !extValid) |=> $stable(extBytes)); // R10
  AST_FAULT_ENDS: assert property (@(posedge clk) disable iff (!rstN) (extReady && extValid && extFault) |=> (done && fault)); // R9
  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN) done |-> !(illegal && fault)); // R9
  AST_STATUS_AT_DONE: assert property (@(posedge clk) disable iff (!rstN) (illegal || fault || descValid) |-> done); // R8
endmodule

bind ea_mode_decoder ea_mode_decoder_chk i_chk (
  .clk(clk), .rstN(rstN), .extValid(extValid), .extFault(extFault), .extReady(extReady),
  .done(done), .descValid(descValid), .illegal(illegal), .fault(fault), .extBytes(extBytes)
);

// File: tb/test_ea_mode_decoder.sv
module test_ea_mode_decoder;
  localparam int F_DIRECT = 0, F_POST = 1, F_PRE = 2, F_OFF = 3, F_IDX = 4;
  localparam int F_ABS = 5, F_PC = 6, F_IMM = 7, F_BSUP = 8, F_MIND = 9;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, start, extValid, extFault;
  logic [5:0] modeReg;
  logic [2:0] immSize;
  logic [511:0] regSnap;
  logic [15:0] extData;
  logic extReady, done, descValid, illegal, fault;
  logic [9:0] eaFlags;
  logic [3:0] baseReg, idxReg, extBytes;
  logic [31:0] baseDisp, outerDisp, absAddr;
  logic [95:0] immed;

  ea_mode_decoder i_ea_mode_decoder (
    .clk(clk), .rstN(rstN), .start(start), .modeReg(modeReg), .immSize(immSize),
    .regSnap(regSnap), .extValid(extValid), .extData(extData), .extFault(extFault),
    .extReady(extReady), .done(done), .descValid(descValid), .illegal(illegal),
    .fault(fault), .eaFlags(eaFlags), .baseReg(baseReg), .idxReg(idxReg),
    .baseDisp(baseDisp), .outerDisp(outerDisp), .absAddr(absAddr), .immed(immed),
    .extBytes(extBytes)
  );

  int checks = 0, failures = 0;
  logic [31:0] regs [16];
  logic [15:0] words [8];
  int eN; bit eIll;
  logic [9:0] eFlags; logic [3:0] eBase, eIdx;
  logic [31:0] eBd, eOd, eAbs; logic [95:0] eImm;

  function automatic logic [31:0] sx16(input logic [15:0] v); return {{16{v[15]}}, v}; endfunction
  function automatic logic [31:0] sx8(input logic [7:0] v); return {{24{v[7]}}, v}; endfunction
  function automatic logic [31:0] fetchDisp(input int p, input int n);
    if (n == 1) return sx16(words[p]);
    if (n == 2) return {words[p], words[p+1]};
    return 32'd0;
  endfunction
  function automatic int sizeCode(input logic [1:0] c);
    return (c == 2'd2) ? 1 : (c == 2'd3) ? 2 : 0;
  endfunction

  task automatic check(input string req, input string what, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic modelExt();
    logic [15:0] x; logic [31:0] idx; int bdN, odN;
    x = words[0]; eN = 1; eIdx = x[15:12];
    idx = regs[x[15:12]];
    if (!x[11]) idx = sx16(idx[15:0]);
    idx = idx << x[10:9];
    if (!x[8]) begin
      eBd = idx + sx8(x[7:0]);
      return;
    end
    if (x[7]) eFlags[F_BSUP] = 1'b1;
    if (x[6] && x[2]) begin eIll = 1; return; end
    if (x[1:0] != 2'd0) eFlags[F_MIND] = 1'b1;
    bdN = sizeCode(x[5:4]); odN = sizeCode(x[1:0]);
    eN = 1 + bdN + odN;
    eBd = fetchDisp(1, bdN) + ((!x[6] && !x[2]) ? idx : 32'd0);
    eOd = fetchDisp(1 + bdN, odN) + ((!x[6] && x[2]) ? idx : 32'd0);
  endtask

  task automatic model(input logic [5:0] m, input logic [2:0] sz);
    eN = 0; eIll = 0; eFlags = '0; eIdx = 0; eBd = 0; eOd = 0; eAbs = 0; eImm = 0;
    eBase = (m[5:3] >= 3'd1 && m[5:3] <= 3'd6) ? {1'b1, m[2:0]} : {1'b0, m[2:0]};
    case (m[5:3])
      3'd0, 3'd1: eFlags[F_DIRECT] = 1'b1;
      3'd3: eFlags[F_POST] = 1'b1;
      3'd4: eFlags[F_PRE] = 1'b1;
      3'd5: begin eFlags[F_OFF] = 1'b1; eN = 1; eBd = sx16(words[0]); end
      3'd6: begin eFlags[F_IDX] = 1'b1; modelExt(); end
      3'd7: case (m[2:0])
        3'd0: begin eFlags[F_ABS] = 1'b1; eN = 1; eAbs = sx16(words[0]); end
        3'd1: begin eFlags[F_ABS] = 1'b1; eN = 2; eAbs = {words[0], words[1]}; end
        3'd2: begin eFlags[F_PC] = 1'b1; eFlags[F_OFF] = 1'b1; eN = 1; eBd = sx16(words[0]); end
        3'd3: begin eFlags[F_PC] = 1'b1; eFlags[F_IDX] = 1'b1; modelExt(); end
        3'd4: begin
          eFlags[F_IMM] = 1'b1;
          case (sz)
            3'd0: begin eN = 1; eImm = {64'd0, sx8(words[0][7:0])}; end
            3'd1: begin eN = 1; eImm = {64'd0, sx16(words[0])}; end
            3'd2: begin eN = 2; eImm = {64'd0, words[0], words[1]}; end
            3'd3: begin eN = 4; eImm = {32'd0, words[0], words[1], words[2], words[3]}; end
            3'd4: begin eN = 6; eImm = {words[0], words[1], words[2], words[3], words[4], words[5]}; end
            default: eIll = 1;
          endcase
        end
        default: eIll = 1;
      endcase
      default: ;
    endcase
  endtask

  function automatic string lbl(input string tag, input logic [95:0] exp);
    return (exp == 96'd0) ? "R12" : tag;
  endfunction

  task automatic runCase(input string tag, input logic [5:0] m, input logic [2:0] sz,
                         input int faultAt, input bit gaps, input bit poke);
    int total, consumed, sent, lastAcc; bit isFault, seen;
    model(m, sz);
    isFault  = (faultAt >= 0) && (faultAt < eN);
    consumed = isFault ? faultAt : eN;
    total    = isFault ? faultAt + 1 : eN;
    @(negedge clk); start = 1'b1; modeReg = m; immSize = sz;
    @(negedge clk); start = 1'b0;
    sent = 0; lastAcc = -1; seen = 0;
    for (int cyc = 0; cyc < 40; cyc++) begin
      extValid = 1'b0; extFault = 1'b0; start = 1'b0;
      check("R10", {tag, " ready"}, 96'(extReady), 96'(sent < total));
      if (done) begin
        seen = 1;
        check("R10", {tag, " done timing"}, 96'(cyc - lastAcc), 96'd1);
        check(isFault ? "R9" : tag, "fault", 96'(fault), 96'(isFault));
        check(eIll ? "R8" : tag, "illegal", 96'(illegal), 96'(eIll && !isFault));
        check(tag, "descValid", 96'(descValid), 96'(!eIll && !isFault));
        check("R10", {tag, " bytes"}, 96'(extBytes), 96'(2 * consumed));
        if (!eIll && !isFault) begin
          check(tag, "flags", 96'(eaFlags), 96'(eFlags));
          check(tag, "baseReg", 96'(baseReg), 96'(eBase));
          check(lbl(tag, 96'(eIdx)), "idxReg", 96'(idxReg), 96'(eIdx));
          check(lbl(tag, 96'(eBd)), "baseDisp", 96'(baseDisp), 96'(eBd));
          check(lbl(tag, 96'(eOd)), "outerDisp", 96'(outerDisp), 96'(eOd));
          check(lbl(tag, 96'(eAbs)), "absAddr", 96'(absAddr), 96'(eAbs));
          check(lbl(tag, eImm), "immed", immed, eImm);
        end
        break;
      end
      if (sent < total && !(gaps && (cyc % 3 == 1))) begin
        extValid = 1'b1; extData = words[sent];
        extFault = isFault && (sent == faultAt);
      end
      if (poke && cyc == 1) begin start = 1'b1; modeReg = 6'o12; end
      if (extValid && extReady) begin sent++; lastAcc = cyc; end
      @(negedge clk);
    end
    if (!seen) check("R10", {tag, " done seen"}, 96'd0, 96'd1);
    extValid = 1'b0; extFault = 1'b0; start = 1'b0;
    @(negedge clk);
    check("R10", {tag, " done single cycle"}, 96'(done), 96'd0);
  endtask

  task automatic setWords(input logic [15:0] a, b, c, d, e, f);
    words[0] = a; words[1] = b; words[2] = c; words[3] = d;
    words[4] = e; words[5] = f; words[6] = 16'h0; words[7] = 16'h0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int k = 0; k < 16; k++) begin
      regs[k] = (32'h0102_0304 * (k + 1)) ^ ((k % 2) ? 32'h0000_8000 : 32'h0);
      regSnap[k*32 +: 32] = regs[k];
    end
    rstN = 1'b0; start = 1'b0; modeReg = '0; immSize = '0;
    extValid = 1'b0; extData = '0; extFault = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "done in reset", 96'(done), 96'd0);
    check("R1", "ready in reset", 96'(extReady), 96'd0);
    check("R1", "bytes in reset", 96'(extBytes), 96'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "done after reset", 96'(done), 96'd0);
    check("R1", "valid after reset", 96'(descValid), 96'd0);

    setWords(16'hFFF0, 16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0, 16'h0F0F);
    runCase("R2", 6'o03, 3'd0, -1, 0, 0);
    runCase("R2", 6'o15, 3'd0, -1, 0, 0);
    runCase("R2", 6'o22, 3'd0, -1, 0, 0);
    runCase("R2", 6'o37, 3'd0, -1, 0, 0);
    runCase("R2", 6'o41, 3'd0, -1, 0, 0);
    runCase("R3", 6'o53, 3'd0, -1, 0, 0);
    setWords(16'h0100, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0);
    runCase("R3", 6'o72, 3'd0, -1, 0, 0);
    setWords(16'h8000, 16'h5678, 16'h0, 16'h0, 16'h0, 16'h0);
    runCase("R4", 6'o70, 3'd0, -1, 0, 0);
    setWords(16'h1234, 16'h5678, 16'h0, 16'h0, 16'h0, 16'h0);
    runCase("R4", 6'o71, 3'd0, -1, 1, 0);

    setWords(16'h12F0, 16'h8765, 16'h4321, 16'hA5A5, 16'h5A5A, 16'hC0DE);
    for (int s = 0; s < 5; s++) runCase("R5", 6'o74, 3'(s), -1, 0, 0);
    setWords(16'h1270, 16'h8765, 16'h4321, 16'hA5A5, 16'h5A5A, 16'hC0DE);
    runCase("R5", 6'o74, 3'd0, -1, 0, 0);
    runCase("R10", 6'o74, 3'd4, -1, 1, 0);

    setWords(16'h9C80, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0);
    runCase("R6", 6'o63, 3'd0, -1, 0, 0);
    setWords(16'h4005, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0);
    runCase("R6", 6'o73, 3'd0, -1, 1, 0);
    setWords(16'h3A7F, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0);
    runCase("R6", 6'o60, 3'd0, -1, 0, 0);

    setWords(16'h2B32, 16'h0001, 16'h0004, 16'hFFFE, 16'h0, 16'h0);
    runCase("R7", 6'o64, 3'd0, -1, 0, 0);
    setWords(16'hA7A7, 16'h8001, 16'h0000, 16'h0010, 16'h0, 16'h0);
    runCase("R7", 6'o73, 3'd0, -1, 1, 0);
    setWords(16'h0150, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0);
    runCase("R7", 6'o61, 3'd0, -1, 0, 0);
    setWords(16'h0151, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0);
    runCase("R7", 6'o61, 3'd0, -1, 0, 0);
    setWords(16'h5923, 16'h7FFF, 16'h0, 16'h0, 16'h0, 16'h0);
    runCase("R7", 6'o66, 3'd0, -1, 0, 0);

    runCase("R8", 6'o75, 3'd0, -1, 0, 0);
    runCase("R8", 6'o77, 3'd0, -1, 0, 0);
    runCase("R8", 6'o74, 3'd5, -1, 0, 0);
    setWords(16'h0144, 16'h1111, 16'h0, 16'h0, 16'h0, 16'h0);
    runCase("R8", 6'o62, 3'd0, -1, 0, 0);

    setWords(16'h1234, 16'h5678, 16'h0, 16'h0, 16'h0, 16'h0);
    runCase("R9", 6'o71, 3'd0, 1, 0, 0);
    setWords(16'h2B32, 16'h0001, 16'h0004, 16'hFFFE, 16'h0, 16'h0);
    runCase("R9", 6'o64, 3'd0, 0, 0, 0);
    runCase("R9", 6'o64, 3'd0, 3, 1, 0);
    runCase("R11", 6'o64, 3'd0, -1, 0, 1);
    runCase("R2", 6'o00, 3'd0, -1, 0, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule